// File: doc/BRIEF.md
# Capture Burst Sequencer

The sequencer turns a single trigger pulse into one coherent snapshot of a six-axis inertial sensor with an on-die temperature channel. When the trigger arrives while the block is idle, it copies the free-running timestamp and the channel-enable mask. It then issues one register read per enabled channel to a register-access engine, using a request/acknowledge port. The engine owns the serial framing and the integrity check. Only the first read of a burst carries the capture flag. That read makes the sensor freeze every channel into its shadow bank, and all later reads of the same burst fetch from that frozen bank.

The returned 16-bit two's-complement words are packed from slot 0 upward into a record, with no holes left for disabled channels. When the last read completes, the block pulses a record-valid strobe together with a done strobe. A read that reports an error abandons the burst: done is pulsed, no record is emitted and no further reads follow. A trigger that arrives while a burst is running is dropped and sets a sticky overrun flag. An empty mask still produces a record that holds only the timestamp.

Top module: `capture_burst_seq`

## Requirements
- R1: After reset, rd_req_o, rec_vld_o, done_o and ovr_o are low, and rec_cnt_o is 0.
- R2: A trigger seen while idle latches ts_i from that same cycle into rec_ts_o. With a non-empty mask, the first read request is raised in the following cycle.
- R3: rd_cap_o is 1 on the first read request of a burst and 0 on every later request of that burst.
- R4: Channel indices are 0 for temperature, 1..3 for acceleration X/Y/Z and 4..6 for rotation rate X/Y/Z. Channel n is read at address 0x17 + n. Only enabled channels are read, each exactly once, in ascending index order.
- R5: The k-th completed read lands in rec_data_o[16k+15:16k]. Slots at or above the number of enabled channels read as zero. rec_cnt_o equals the number of enabled channels.
- R6: A read acknowledged with rd_err_i high ends the burst. In the next cycle done_o pulses with rec_vld_o low, and no further request is issued.
- R7: On success, rec_vld_o and done_o are high together for exactly one cycle: the cycle after the final acknowledge.
- R8: A trigger that arrives while a burst is in progress starts nothing. It sets ovr_o, which stays high until reset. This also applies when the trigger falls in the cycle of the final acknowledge.
- R9: A trigger with an all-zero mask issues no read. In the next cycle it raises rec_vld_o and done_o with rec_cnt_o = 0 and the latched timestamp.
- R10: A request holds its address and capture flag unchanged until it is acknowledged.
- R11: The mask is sampled only at the trigger. Changes to en_mask_i during a burst have no effect on which channels are read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Snapshot trigger pulse |
| en_mask_i | input | NCH (7) | Channel enable, bit n selects channel n |
| ts_i | input | TSW (32) | Free-running timestamp |
| rd_req_o | output | 1 | Read request to the register-access engine |
| rd_addr_o | output | AW (8) | Register address of the request |
| rd_cap_o | output | 1 | Capture flag carried by the request |
| rd_ack_i | input | 1 | Read completed this cycle |
| rd_err_i | input | 1 | Completed read failed (valid with rd_ack_i) |
| rd_data_i | input | DW (16) | Returned sample (valid with rd_ack_i) |
| rec_vld_o | output | 1 | Record valid strobe |
| rec_data_o | output | NCH*DW (112) | Packed samples, slot 0 in the low bits |
| rec_cnt_o | output | 3 | Number of valid slots |
| rec_ts_o | output | TSW (32) | Timestamp latched at the trigger |
| done_o | output | 1 | Burst finished (success or error) |
| ovr_o | output | 1 | Sticky dropped-trigger flag |

## Verification
The two functions that can fall into one cycle are a new trigger and the completion of a burst's final read. The completion emits the record, and the trigger may start another burst or be dropped. The bench provokes this by letting its read responder raise the trigger in the same cycle as the last acknowledge. It then judges that the record is emitted intact, that ovr_o rises, and that no new request appears in the following cycles. The same bench also triggers well inside a burst and confirms that the handshake count and the record stay those of the original mask.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
    typedef enum logic [0:0] {
        CBS_IDLE = 1'b0,
        CBS_READ = 1'b1
    } cbs_state_e;
endpackage

// File: rtl/cbs_lowest_set.sv
module cbs_lowest_set #(
    parameter int W  = 7,
    parameter int IW = 3
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end

    // R4: the chosen index must point at an enabled channel
    always_comb begin
        if (!$isunknown(vec) && any) begin
            a_r4_pick_is_set: assert (vec[idx]);
        end
    end
endmodule

// File: rtl/cbs_slot_write.sv
module cbs_slot_write #(
    parameter int NCH = 7,
    parameter int DW  = 16,
    parameter int CW  = 3
) (
    input  logic [NCH*DW-1:0] rec_in,
    input  logic [CW-1:0]     slot,
    input  logic [DW-1:0]     data,
    input  logic              we,
    input  logic              clr,
    output logic [NCH*DW-1:0] rec_out
);
    for (genvar g = 0; g < NCH; g++) begin : g_slot
        assign rec_out[g*DW +: DW] = clr ? '0 :
                                     (we && slot == CW'(g)) ? data :
                                     rec_in[g*DW +: DW];
    end
endmodule

// File: rtl/capture_burst_seq.sv
module capture_burst_seq #(
    parameter int              NCH       = 7,
    parameter int              DW        = 16,
    parameter int              AW        = 8,
    parameter int              TSW       = 32,
    parameter logic [AW-1:0]   BASE_ADDR = 8'h17
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         trig_i,
    input  logic [NCH-1:0]               en_mask_i,
    input  logic [TSW-1:0]               ts_i,
    output logic                         rd_req_o,
    output logic [AW-1:0]                rd_addr_o,
    output logic                         rd_cap_o,
    input  logic                         rd_ack_i,
    input  logic                         rd_err_i,
    input  logic [DW-1:0]                rd_data_i,
    output logic                         rec_vld_o,
    output logic [NCH*DW-1:0]            rec_data_o,
    output logic [$clog2(NCH+1)-1:0]     rec_cnt_o,
    output logic [TSW-1:0]               rec_ts_o,
    output logic                         done_o,
    output logic                         ovr_o
);
    import cbs_pkg::*;

    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CW = $clog2(NCH + 1);
    localparam int RW = NCH * DW;

    typedef struct packed {
        cbs_state_e     st;
        logic [NCH-1:0] rem;
        logic [IW-1:0]  idx;
        logic [CW-1:0]  slot;
        logic           first;
        logic [RW-1:0]  rec;
        logic [TSW-1:0] ts;
        logic           vld;
        logic           done;
        logic           ovr;
    } regs_t;

    regs_t q, d;

    logic [NCH-1:0] rem_clr;
    logic [NCH-1:0] pick_vec;
    logic [IW-1:0]  pick_idx;
    logic           pick_any;
    logic           hs;
    logic           slot_we;
    logic           rec_clr;
    logic [RW-1:0]  rec_next;

    assign hs       = (q.st == CBS_READ) && rd_ack_i;
    assign rem_clr  = q.rem & ~(NCH'(1) << q.idx);
    assign pick_vec = (q.st == CBS_IDLE) ? en_mask_i : rem_clr;

    cbs_lowest_set #(.W(NCH), .IW(IW)) u_pick (
        .vec (pick_vec),
        .idx (pick_idx),
        .any (pick_any)
    );

    cbs_slot_write #(.NCH(NCH), .DW(DW), .CW(CW)) u_pack (
        .rec_in  (q.rec),
        .slot    (q.slot),
        .data    (rd_data_i),
        .we      (slot_we),
        .clr     (rec_clr),
        .rec_out (rec_next)
    );

    always_comb begin
        d       = q;
        d.vld   = 1'b0;
        d.done  = 1'b0;
        slot_we = 1'b0;
        rec_clr = 1'b0;
        unique case (q.st)
            CBS_IDLE: begin
                if (trig_i) begin
                    rec_clr = 1'b1;
                    d.ts    = ts_i;
                    d.slot  = '0;
                    d.first = 1'b1;
                    d.rem   = en_mask_i;
                    d.idx   = pick_idx;
                    if (pick_any) begin
                        d.st = CBS_READ;
                    end else begin
                        d.vld  = 1'b1;
                        d.done = 1'b1;
                    end
                end
            end
            CBS_READ: begin
                if (trig_i) begin
                    d.ovr = 1'b1;
                end
                if (hs) begin
                    d.first = 1'b0;
                    if (rd_err_i) begin
                        d.st   = CBS_IDLE;
                        d.done = 1'b1;
                    end else begin
                        slot_we = 1'b1;
                        d.slot  = q.slot + 1'b1;
                        d.rem   = rem_clr;
                        d.idx   = pick_idx;
                        if (!pick_any) begin
                            d.st   = CBS_IDLE;
                            d.vld  = 1'b1;
                            d.done = 1'b1;
                        end
                    end
                end
            end
            default: d.st = CBS_IDLE;
        endcase
        d.rec = rec_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_req_o   = (q.st == CBS_READ);
    assign rd_addr_o  = BASE_ADDR + AW'(q.idx);
    assign rd_cap_o   = rd_req_o & q.first;
    assign rec_vld_o  = q.vld;
    assign rec_data_o = q.rec;
    assign rec_cnt_o  = q.slot;
    assign rec_ts_o   = q.ts;
    assign done_o     = q.done;
    assign ovr_o      = q.ovr;

    // R2, R3: an idle trigger with channels enabled opens a capturing read
    a_r3_cap_on_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req_o && trig_i && (|en_mask_i)) |=> (rd_req_o && rd_cap_o));

    // R3: after a good read, any further request of the burst has no capture
    a_r3_no_cap_later: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i && !rd_err_i) |=> !rd_cap_o);

    // R4: addresses stay in the captured bank
    a_r4_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (rd_addr_o >= BASE_ADDR && int'(rd_addr_o) < int'(BASE_ADDR) + NCH));

    // R4: channels are visited strictly ascending
    a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i && !rd_err_i) |=> (!rd_req_o || rd_addr_o > $past(rd_addr_o)));

    // R6: a failed read ends the burst without a record
    a_r6_err_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i && rd_err_i) |=> (done_o && !rec_vld_o && !rd_req_o));

    // R7: a record always comes with done
    a_r7_vld_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        rec_vld_o |-> done_o);

    // R8: a trigger during a burst raises the overrun flag
    a_r8_busy_trig: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && trig_i) |=> ovr_o);

    // R8: overrun is sticky
    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o |=> ovr_o);

    // R9: an empty mask gives an immediate, empty record
    a_r9_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req_o && trig_i && en_mask_i == '0) |=> (rec_vld_o && rec_cnt_o == '0 && !rd_req_o));

    // R10: a pending request is held steady
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o) && $stable(rd_cap_o)));
endmodule

// File: tb/tb_capture_burst_seq.sv
`timescale 1ns/1ps
module tb_capture_burst_seq;
    localparam int NCH = 7;
    localparam int DW  = 16;
    localparam int NV  = 8;

    localparam logic [6:0] VMASK [NV] = '{7'h7F, 7'h01, 7'h40, 7'h55, 7'h2A, 7'h12, 7'h7E, 7'h08};
    localparam int         VLAT  [NV] = '{0, 1, 2, 3, 0, 2, 1, 3};
    localparam int         VCNT  [NV] = '{7, 1, 1, 4, 3, 2, 6, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_a = 1'b0, trig_b = 1'b0;
    logic trig;
    logic [6:0] en_mask = '0;
    logic [31:0] ts = '0;
    logic ack = 1'b0, err = 1'b0;
    logic [15:0] rdata = '0;
    logic rd_req, rd_cap, rec_vld, done, ovr;
    logic [7:0] rd_addr;
    logic [NCH*DW-1:0] rec_data;
    logic [2:0] rec_cnt;
    logic [31:0] rec_ts;

    assign trig = trig_a | trig_b;

    int errors = 0, checks = 0;
    int lat = 0, err_addr = -1, seed = 0, wcnt = 0, hs_cnt = 0;
    int trig_on_last = 0, last_n = 0, hold_bad = 0;
    int log_addr [16];
    int log_cap  [16];
    logic [7:0] prev_addr = '0;

    always #4 clk = ~clk;

    capture_burst_seq dut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .en_mask_i(en_mask), .ts_i(ts),
        .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_cap_o(rd_cap),
        .rd_ack_i(ack), .rd_err_i(err), .rd_data_i(rdata),
        .rec_vld_o(rec_vld), .rec_data_o(rec_data), .rec_cnt_o(rec_cnt),
        .rec_ts_o(rec_ts), .done_o(done), .ovr_o(ovr)
    );

    function automatic logic [15:0] fn(int a, int s);
        return 16'((a * 2731 + s * 977) & 16'hFFFF);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // responder: register-access engine model, drives at negedge
    initial begin
        forever begin
            @(negedge clk);
            trig_b = 1'b0;
            if (!rst_n) begin
                ack = 1'b0; err = 1'b0; wcnt = 0;
            end else if (ack) begin
                ack = 1'b0; err = 1'b0; wcnt = 0;
            end else if (rd_req === 1'b1) begin
                if (wcnt > 0 && rd_addr != prev_addr) hold_bad = 1;
                prev_addr = rd_addr;
                if (wcnt >= lat) begin
                    ack   = 1'b1;
                    rdata = fn(int'(rd_addr), seed);
                    err   = (int'(rd_addr) == err_addr);
                    if (hs_cnt < 16) begin
                        log_addr[hs_cnt] = int'(rd_addr);
                        log_cap[hs_cnt]  = int'(rd_cap);
                    end
                    hs_cnt++;
                    if (trig_on_last != 0 && hs_cnt == last_n) trig_b = 1'b1;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // trigger for one cycle, then scramble mask and timestamp (R11)
    task automatic go(input logic [6:0] mask, input logic [31:0] tsv);
        @(negedge clk);
        hs_cnt  = 0;
        en_mask = mask;
        ts      = tsv;
        trig_a  = 1'b1;
        @(negedge clk);
        trig_a  = 1'b0;
        en_mask = ~mask;
        ts      = tsv ^ 32'h5A5A_0F0F;
        chk(rd_req == (mask != 0), "R2", "request one cycle after trigger", rd_req, mask != 0);
        if (mask != 0) chk(rd_cap == 1'b1, "R3", "capture on first request", rd_cap, 1);
    endtask

    task automatic wait_done();
        int n = 0;
        while (done !== 1'b1 && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic verify_record(input logic [6:0] mask, input logic [31:0] tsv, input int ecnt_tab);
        int ecnt = 0;
        int eaddr [7];
        for (int k = 0; k < NCH; k++) begin
            if (mask[k]) begin
                eaddr[ecnt] = 8'h17 + k;
                ecnt++;
            end
        end
        chk(ecnt == ecnt_tab, "R5", "table count", ecnt, ecnt_tab);
        chk(done == 1'b1 && rec_vld == 1'b1, "R7", "record and done together", {done, rec_vld}, 2'b11);
        chk(hs_cnt == ecnt, "R4", "read count", hs_cnt, ecnt);
        chk(rec_cnt == 3'(ecnt), "R5", "record count", rec_cnt, ecnt);
        chk(rec_ts == tsv, "R2", "latched timestamp", rec_ts, tsv);
        for (int i = 0; i < ecnt && i < 16; i++) begin
            chk(log_addr[i] == eaddr[i], "R4", "read address order", log_addr[i], eaddr[i]);
            chk(log_cap[i] == ((i == 0) ? 1 : 0), "R3", "capture flag per read", log_cap[i], (i == 0) ? 1 : 0);
        end
        for (int s = 0; s < NCH; s++) begin
            logic [15:0] e;
            e = (s < ecnt) ? fn(eaddr[s], seed) : 16'h0000;
            chk(rec_data[s*DW +: DW] == e, "R5", "packed slot", rec_data[s*DW +: DW], e);
        end
        @(negedge clk);
        chk(done == 1'b0 && rec_vld == 1'b0, "R7", "strobes last one cycle", {done, rec_vld}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1: reset state
        chk({rd_req, rec_vld, done, ovr} == 4'b0 && rec_cnt == 0, "R1", "reset outputs",
            {rd_req, rec_vld, done, ovr, rec_cnt}, 0);

        // table-driven bursts (R2..R5, R7, R10, R11)
        for (int v = 0; v < NV; v++) begin
            logic [31:0] tsv;
            lat  = VLAT[v];
            seed = v + 3;
            tsv  = 32'h1000_0000 + 32'(v * 4099);
            go(VMASK[v], tsv);
            wait_done();
            verify_record(VMASK[v], tsv, VCNT[v]);
        end
        chk(hold_bad == 0, "R10", "address held while waiting", hold_bad, 0);
        chk(ovr == 1'b0, "R8", "no overrun in spaced bursts", ovr, 0);

        // R9: empty mask
        go(7'h00, 32'hCAFE_0001);
        chk(rec_vld == 1'b1 && done == 1'b1 && rec_cnt == 0, "R9", "empty record",
            {rec_vld, done, rec_cnt}, 5'b11000);
        chk(rec_ts == 32'hCAFE_0001, "R9", "timestamp in empty record", rec_ts, 32'hCAFE_0001);
        chk(rec_data == '0, "R9", "empty record data", rec_data[63:0], 0);
        repeat (3) @(negedge clk);
        chk(hs_cnt == 0, "R9", "no reads for empty mask", hs_cnt, 0);

        // R6: error on the fourth read
        lat = 1; seed = 21; err_addr = 8'h17 + 3;
        go(7'h7F, 32'h0BAD_0004);
        wait_done();
        chk(done == 1'b1 && rec_vld == 1'b0, "R6", "done without record", {done, rec_vld}, 2'b10);
        repeat (8) @(negedge clk);
        chk(hs_cnt == 4 && rd_req == 1'b0, "R6", "no reads after error", hs_cnt, 4);

        // R6: error on the very first read
        err_addr = 8'h17 + 2;
        go(7'h24, 32'h0BAD_0001);
        wait_done();
        chk(done == 1'b1 && rec_vld == 1'b0, "R6", "first-read error", {done, rec_vld}, 2'b10);
        repeat (8) @(negedge clk);
        chk(hs_cnt == 1, "R6", "single read before abort", hs_cnt, 1);
        err_addr = -1;

        // recovery after error
        lat = 0; seed = 33;
        go(7'h24, 32'h0000_AAAA);
        wait_done();
        verify_record(7'h24, 32'h0000_AAAA, 2);

        // R8: trigger well inside a burst
        do_reset();
        lat = 3; seed = 44;
        go(7'h7F, 32'h7777_0000);
        repeat (4) @(negedge clk);
        trig_a = 1'b1; en_mask = 7'h01;
        @(negedge clk);
        trig_a = 1'b0;
        chk(ovr == 1'b1, "R8", "overrun after busy trigger", ovr, 1);
        wait_done();
        verify_record(7'h7F, 32'h7777_0000, 7);
        repeat (10) @(negedge clk);
        chk(hs_cnt == 7 && rd_req == 1'b0, "R8", "busy trigger started nothing", hs_cnt, 7);
        lat = 1; seed = 45;
        go(7'h03, 32'h7777_0001);
        wait_done();
        chk(ovr == 1'b1, "R8", "overrun sticky across bursts", ovr, 1);

        // R1/R8: reset clears overrun
        do_reset();
        @(negedge clk);
        chk(ovr == 1'b0, "R1", "reset clears overrun", ovr, 0);

        // R8: trigger in the same cycle as the final acknowledge
        lat = 1; seed = 55; trig_on_last = 1; last_n = 7;
        go(7'h7F, 32'h5555_1234);
        wait_done();
        trig_on_last = 0;
        verify_record(7'h7F, 32'h5555_1234, 7);
        chk(ovr == 1'b1, "R8", "overrun on coincident trigger", ovr, 1);
        repeat (10) @(negedge clk);
        chk(hs_cnt == 7 && rd_req == 1'b0, "R8", "coincident trigger started nothing", hs_cnt, 7);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule